// File: doc/BRIEF.md
# SMBus Slave Transaction Decoder

This block sits behind a byte-level bus slave front end that has already matched the slave address and handles the wire protocol. Each cycle it takes at most one bus event: start with write direction, start with read direction, a byte written by the master, a request for a byte to return, a master NACK, or a stop. From this stream it works out which SMBus transaction the master is running and reports it to an application register file through single-cycle strobes.

Written bytes are collected in a small buffer. The block decides what they meant only at a stop or at a repeated start. At a stop, no bytes means a quick command with write direction and one byte means a send byte. Two or more bytes form a write burst: a command byte followed by payload bytes. At a repeated start, the buffered bytes become the command for a read that follows. Reads are answered in the same cycle. The block forwards the request to the application, together with the latched command and a running byte index, and passes the returned byte back to the front end. Any event that makes no sense in the current phase puts the block into an error state, and that state lasts until the next stop.

Top module: `smbus_slave_decoder`

## Requirements
- R1: After reset the block is idle. No strobe is active, `proto_err` and `buf_ovf` are 0, and `app_rd_req` is 0.
- R2: A start with write direction from idle begins write collection. A start with write direction in any other phase sets `proto_err`.
- R3: Written bytes are stored only while collecting. In any other phase they are ignored and change neither the error flag nor the byte count. Payload byte i, which is the (i+1)-th byte written, appears on `wr_payload[8*i +: 8]`.
- R4: A stop during write collection produces a strobe in the cycle after the stop edge. With 0 bytes it is `quick_stb` with `quick_dir`=0. With 1 byte it is `send_stb` with that byte on `send_data`. With 2 or more bytes it is `wr_stb`, with `wr_cmd` set to the first byte and `wr_len` set to the byte count minus one.
- R5: A start with read direction from idle enters single-byte receive. A stop there gives `quick_stb` with `quick_dir`=1. A read there asserts `app_rd_req` with `app_rd_seq`=0, returns `app_rd_data` on `bus_rd_data`, and ends the transfer.
- R6: A start with read direction during write collection behaves by byte count. With 0 bytes it sets `proto_err`. With 1 byte it latches that byte as the command and gives no strobe. With 2 or more bytes it first issues the R4 write burst strobe. The legal cases then enter sequential read with index 0. A start with read direction in any other phase sets `proto_err`.
- R7: In sequential read, each read asserts `app_rd_req` with `app_rd_seq`=1, the latched command on `app_rd_cmd` and the index on `app_rd_idx`, and returns `app_rd_data`. The index then increments modulo 2^IDX_W.
- R8: A NACK ends a sequential read and leaves an ended transfer unchanged, without error. A NACK in any other phase sets `proto_err`.
- R9: A read in any phase other than single-byte receive or sequential read returns 0x00, asserts no `app_rd_req`, and sets `proto_err`.
- R10: `proto_err` stays set until a stop. Every stop returns the block to idle, clears `proto_err` and the byte count, and produces no strobe unless R4 or R5 applies.
- R11: Bytes written after BUF_BYTES are already held are dropped and set `buf_ovf`. Stored bytes are not overwritten. `buf_ovf` clears at the next legal write start.
- R12: At most one bus event is presented per cycle. Each strobe lasts one cycle, and at most one strobe is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start_wr | input | 1 | Start or repeated start, write direction |
| ev_start_rd | input | 1 | Start or repeated start, read direction |
| ev_wr_byte | input | 1 | Master wrote a byte |
| ev_wr_data | input | 8 | Byte written by the master |
| ev_rd_byte | input | 1 | Front end needs a byte for the master |
| ev_nack | input | 1 | Master NACKed a read byte |
| ev_stop | input | 1 | Stop condition |
| bus_rd_data | output | 8 | Byte returned for the current read (combinational) |
| app_rd_req | output | 1 | Read request to the application (combinational) |
| app_rd_seq | output | 1 | 1 = indexed sequential read, 0 = single receive byte |
| app_rd_cmd | output | 8 | Latched command for sequential reads |
| app_rd_idx | output | IDX_W | Byte index within the sequential read |
| app_rd_data | input | 8 | Application's answer to the read request |
| quick_stb | output | 1 | Quick command pulse |
| quick_dir | output | 1 | Quick command direction, 1 = read |
| send_stb | output | 1 | Send-byte pulse |
| send_data | output | 8 | Byte of the send-byte transaction |
| wr_stb | output | 1 | Write burst pulse |
| wr_cmd | output | 8 | Command byte of the burst |
| wr_len | output | LEN_W | Number of payload bytes in the burst |
| wr_payload | output | 8*(BUF_BYTES-1) | Payload bytes, byte i at bits 8i+7:8i |
| proto_err | output | 1 | Protocol error state |
| buf_ovf | output | 1 | Write buffer overflow seen |

## Verification
The bench builds the decoder with BUF_BYTES=6 and IDX_W=3. The small buffer lets a seven-byte write reach the overflow rule and its no-overwrite behaviour. The three-bit index lets a nine-byte sequential read show the index wrapping back to zero and repeating the first answer. Every other transaction shape, along with each illegal event in each phase, is independent of these sizes and runs unchanged.

// File: rtl/smbus_slave_decoder.sv
module smbus_slave_decoder #(
  parameter int BUF_BYTES = 34,
  parameter int IDX_W     = 8,
  localparam int LEN_W    = $clog2(BUF_BYTES + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ev_start_wr,
  input  logic                       ev_start_rd,
  input  logic                       ev_wr_byte,
  input  logic [7:0]                 ev_wr_data,
  input  logic                       ev_rd_byte,
  input  logic                       ev_nack,
  input  logic                       ev_stop,
  output logic [7:0]                 bus_rd_data,
  output logic                       app_rd_req,
  output logic                       app_rd_seq,
  output logic [7:0]                 app_rd_cmd,
  output logic [IDX_W-1:0]           app_rd_idx,
  input  logic [7:0]                 app_rd_data,
  output logic                       quick_stb,
  output logic                       quick_dir,
  output logic                       send_stb,
  output logic [7:0]                 send_data,
  output logic                       wr_stb,
  output logic [7:0]                 wr_cmd,
  output logic [LEN_W-1:0]           wr_len,
  output logic [8*(BUF_BYTES-1)-1:0] wr_payload,
  output logic                       proto_err,
  output logic                       buf_ovf
);
  localparam int IW = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1;

  typedef enum logic [2:0] {S_IDLE, S_WDATA, S_RBYTE, S_RDATA, S_DONE, S_ERR} state_t;

  state_t            state_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [7:0]        cmd_q;
  logic [7:0]        mem_q [BUF_BYTES];

  logic hi_ev, in_w, take_byte, room;
  logic quick_d, send_d, wr_d;

  assign hi_ev     = ev_stop | ev_start_wr | ev_start_rd | ev_nack | ev_rd_byte;
  assign in_w      = (state_q == S_WDATA);
  assign room      = (cnt_q < LEN_W'(BUF_BYTES));
  assign take_byte = ev_wr_byte && !hi_ev && in_w;

  assign quick_d = ev_stop && ((in_w && cnt_q == '0) || state_q == S_RBYTE);
  assign send_d  = ev_stop && in_w && (cnt_q == LEN_W'(1));
  assign wr_d    = (ev_stop || ev_start_rd) && in_w && (cnt_q > LEN_W'(1));

  assign app_rd_req  = ev_rd_byte && !(ev_stop | ev_start_wr | ev_start_rd | ev_nack)
                       && (state_q == S_RBYTE || state_q == S_RDATA);
  assign app_rd_seq  = (state_q == S_RDATA);
  assign app_rd_cmd  = cmd_q;
  assign app_rd_idx  = idx_q;
  assign bus_rd_data = app_rd_req ? app_rd_data : 8'h00;
  assign proto_err   = (state_q == S_ERR);

  for (genvar g = 0; g < BUF_BYTES - 1; g++) begin : g_pay
    assign wr_payload[8*g +: 8] = mem_q[g+1];
  end

  always_ff @(posedge clk) begin
    if (take_byte && room) mem_q[cnt_q[IW-1:0]] <= ev_wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quick_stb <= 1'b0;
      quick_dir <= 1'b0;
      send_stb  <= 1'b0;
      send_data <= '0;
      wr_stb    <= 1'b0;
      wr_cmd    <= '0;
      wr_len    <= '0;
    end else begin
      quick_stb <= quick_d;
      send_stb  <= send_d;
      wr_stb    <= wr_d;
      if (quick_d) quick_dir <= (state_q == S_RBYTE);
      if (send_d)  send_data <= mem_q[0];
      if (wr_d) begin
        wr_cmd <= mem_q[0];
        wr_len <= cnt_q - LEN_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      cmd_q   <= '0;
      buf_ovf <= 1'b0;
    end else if (ev_stop) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else if (ev_start_wr) begin
      if (state_q == S_IDLE) begin
        state_q <= S_WDATA;
        buf_ovf <= 1'b0;
      end else begin
        state_q <= S_ERR;
      end
    end else if (ev_start_rd) begin
      case (state_q)
        S_IDLE:  state_q <= S_RBYTE;
        S_WDATA: begin
          if (cnt_q == '0) begin
            state_q <= S_ERR;
          end else begin
            cmd_q   <= mem_q[0];
            cnt_q   <= '0;
            idx_q   <= '0;
            state_q <= S_RDATA;
          end
        end
        default: state_q <= S_ERR;
      endcase
    end else if (ev_nack) begin
      if (state_q == S_RDATA || state_q == S_DONE) state_q <= S_DONE;
      else                                          state_q <= S_ERR;
    end else if (ev_rd_byte) begin
      case (state_q)
        S_RBYTE: state_q <= S_DONE;
        S_RDATA: idx_q   <= idx_q + IDX_W'(1);
        default: state_q <= S_ERR;
      endcase
    end else if (take_byte) begin
      if (room) cnt_q   <= cnt_q + LEN_W'(1);
      else      buf_ovf <= 1'b1;
    end
  end

  assert_evt_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_start_wr, ev_start_rd, ev_wr_byte, ev_rd_byte, ev_nack, ev_stop}));

  assert_one_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({quick_stb, send_stb, wr_stb}));

  assert_strobe_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (send_stb || wr_stb) |=> !(send_stb || wr_stb));

  assert_quick_after_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    quick_stb |-> $past(ev_stop));

  assert_err_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (proto_err && !ev_stop) |=> proto_err);

  assert_err_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !proto_err);

  assert_idx_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (app_rd_req && app_rd_seq) |=> (app_rd_idx == $past(app_rd_idx) + IDX_W'(1)));

  assert_bad_read_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd_byte && !app_rd_req && !ev_stop) |=> proto_err);

  assert_ovf_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_ovf) |-> $past(ev_wr_byte));

endmodule

// File: tb/sim_smbus_slave_decoder.sv
module sim_smbus_slave_decoder;
  localparam int BUF   = 6;
  localparam int IDXW  = 3;
  localparam int LENW  = $clog2(BUF + 1);

  localparam logic [2:0] E_NO = 3'd0, E_SW = 3'd1, E_SR = 3'd2, E_WB = 3'd3,
                         E_RB = 3'd4, E_NK = 3'd5, E_SP = 3'd6;
  localparam logic [2:0] K_NO = 3'd0, K_ER = 3'd1, K_QK = 3'd2, K_SD = 3'd3,
                         K_WR = 3'd4, K_RD = 3'd5, K_NS = 3'd6;

  // {req, event, data, check kind, expected}
  localparam int NV = 55;
  localparam logic [33:0] VEC [NV] = '{
    {4'd2,  E_SW, 8'h00, K_NO, 16'h0000},   // R2 quick write
    {4'd4,  E_SP, 8'h00, K_QK, 16'h0000},   // R4
    {4'd5,  E_SR, 8'h00, K_NO, 16'h0000},   // R5 quick read
    {4'd5,  E_SP, 8'h00, K_QK, 16'h0001},
    {4'd2,  E_SW, 8'h00, K_NO, 16'h0000},   // R4 send byte
    {4'd3,  E_WB, 8'h3C, K_NO, 16'h0000},
    {4'd4,  E_SP, 8'h00, K_SD, 16'h003C},
    {4'd2,  E_SW, 8'h00, K_NO, 16'h0000},   // R4 write burst
    {4'd3,  E_WB, 8'h10, K_NO, 16'h0000},
    {4'd3,  E_WB, 8'h11, K_NO, 16'h0000},
    {4'd3,  E_WB, 8'h12, K_NO, 16'h0000},
    {4'd4,  E_SP, 8'h00, K_WR, 16'h1002},
    {4'd5,  E_SR, 8'h00, K_NO, 16'h0000},   // R5 receive byte
    {4'd5,  E_RB, 8'h00, K_RD, 16'h005A},
    {4'd8,  E_NK, 8'h00, K_ER, 16'h0000},   // R8 NACK in done
    {4'd10, E_SP, 8'h00, K_NS, 16'h0000},   // R10
    {4'd2,  E_SW, 8'h00, K_NO, 16'h0000},   // R6 single command byte
    {4'd3,  E_WB, 8'h20, K_NO, 16'h0000},
    {4'd6,  E_SR, 8'h00, K_NS, 16'h0000},
    {4'd7,  E_RB, 8'h00, K_RD, 16'h0020},   // R7
    {4'd7,  E_RB, 8'h00, K_RD, 16'h0021},
    {4'd8,  E_NK, 8'h00, K_ER, 16'h0000},
    {4'd8,  E_NK, 8'h00, K_ER, 16'h0000},
    {4'd10, E_SP, 8'h00, K_NS, 16'h0000},
    {4'd2,  E_SW, 8'h00, K_NO, 16'h0000},   // R6 burst then read
    {4'd3,  E_WB, 8'h30, K_NO, 16'h0000},
    {4'd3,  E_WB, 8'h31, K_NO, 16'h0000},
    {4'd6,  E_SR, 8'h00, K_WR, 16'h3001},
    {4'd7,  E_RB, 8'h00, K_RD, 16'h0030},
    {4'd10, E_SP, 8'h00, K_NS, 16'h0000},
    {4'd2,  E_SW, 8'h00, K_NO, 16'h0000},   // R6 read after empty write
    {4'd6,  E_SR, 8'h00, K_ER, 16'h0001},
    {4'd3,  E_WB, 8'h55, K_ER, 16'h0001},   // R3
    {4'd10, E_SW, 8'h00, K_ER, 16'h0001},
    {4'd10, E_SP, 8'h00, K_ER, 16'h0000},
    {4'd2,  E_SW, 8'h00, K_NO, 16'h0000},   // R2 second start
    {4'd2,  E_SW, 8'h00, K_ER, 16'h0001},
    {4'd10, E_SP, 8'h00, K_ER, 16'h0000},
    {4'd9,  E_RB, 8'h00, K_RD, 16'h0000},   // R9 read in idle
    {4'd9,  E_NO, 8'h00, K_ER, 16'h0001},
    {4'd10, E_SP, 8'h00, K_ER, 16'h0000},
    {4'd8,  E_NK, 8'h00, K_ER, 16'h0001},   // R8 NACK in idle
    {4'd10, E_SP, 8'h00, K_ER, 16'h0000},
    {4'd3,  E_WB, 8'h77, K_ER, 16'h0000},   // R3 write in idle
    {4'd3,  E_SW, 8'h00, K_NO, 16'h0000},
    {4'd3,  E_SP, 8'h00, K_QK, 16'h0000},
    {4'd5,  E_SR, 8'h00, K_NO, 16'h0000},   // R9 read after done
    {4'd5,  E_RB, 8'h00, K_RD, 16'h005A},
    {4'd9,  E_RB, 8'h00, K_RD, 16'h0000},
    {4'd10, E_SP, 8'h00, K_ER, 16'h0000},
    {4'd2,  E_SW, 8'h00, K_NO, 16'h0000},   // R6 start-receive in read
    {4'd3,  E_WB, 8'h40, K_NO, 16'h0000},
    {4'd6,  E_SR, 8'h00, K_NO, 16'h0000},
    {4'd6,  E_SR, 8'h00, K_ER, 16'h0001},
    {4'd10, E_SP, 8'h00, K_ER, 16'h0000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_start_wr = 0, ev_start_rd = 0, ev_wr_byte = 0, ev_rd_byte = 0, ev_nack = 0, ev_stop = 0;
  logic [7:0] ev_wr_data = '0;
  logic [7:0] bus_rd_data, app_rd_cmd, app_rd_data, send_data, wr_cmd;
  logic app_rd_req, app_rd_seq, quick_stb, quick_dir, send_stb, wr_stb, proto_err, buf_ovf;
  logic [IDXW-1:0] app_rd_idx;
  logic [LENW-1:0] wr_len;
  logic [8*(BUF-1)-1:0] wr_payload;

  int checks = 0, errors = 0;
  logic [7:0] rdb;
  logic rdreq;

  always #5 clk = ~clk;

  assign app_rd_data = app_rd_seq ? app_rd_cmd + 8'(app_rd_idx) : 8'h5A;

  smbus_slave_decoder #(.BUF_BYTES(BUF), .IDX_W(IDXW)) u0 (
    .clk(clk), .rst_n(rst_n), .ev_start_wr(ev_start_wr), .ev_start_rd(ev_start_rd),
    .ev_wr_byte(ev_wr_byte), .ev_wr_data(ev_wr_data), .ev_rd_byte(ev_rd_byte),
    .ev_nack(ev_nack), .ev_stop(ev_stop), .bus_rd_data(bus_rd_data),
    .app_rd_req(app_rd_req), .app_rd_seq(app_rd_seq), .app_rd_cmd(app_rd_cmd),
    .app_rd_idx(app_rd_idx), .app_rd_data(app_rd_data), .quick_stb(quick_stb),
    .quick_dir(quick_dir), .send_stb(send_stb), .send_data(send_data),
    .wr_stb(wr_stb), .wr_cmd(wr_cmd), .wr_len(wr_len), .wr_payload(wr_payload),
    .proto_err(proto_err), .buf_ovf(buf_ovf)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] ev, input logic [7:0] d);
    @(negedge clk);
    ev_start_wr = (ev == E_SW);
    ev_start_rd = (ev == E_SR);
    ev_wr_byte  = (ev == E_WB);
    ev_rd_byte  = (ev == E_RB);
    ev_nack     = (ev == E_NK);
    ev_stop     = (ev == E_SP);
    ev_wr_data  = d;
    #1;
    rdb   = bus_rd_data;
    rdreq = app_rd_req;
    @(negedge clk);
    {ev_start_wr, ev_start_rd, ev_wr_byte, ev_rd_byte, ev_nack, ev_stop} = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({quick_stb, send_stb, wr_stb, proto_err, buf_ovf, app_rd_req} == 6'b0, "R1",
          {quick_stb, send_stb, wr_stb, proto_err, buf_ovf, app_rd_req}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [3:0]  r;
      logic [2:0]  ev, k;
      logic [7:0]  d;
      logic [15:0] e;
      string       tag;
      {r, ev, d, k, e} = VEC[i];
      tag = $sformatf("R%0d", r);
      step(ev, d);
      case (k)
        K_ER: check(proto_err == e[0], tag, proto_err, e[0]);
        K_QK: check(quick_stb && quick_dir == e[0], tag, {quick_stb, quick_dir}, {1'b1, e[0]});
        K_SD: check(send_stb && send_data == e[7:0], tag, {send_stb, send_data}, {1'b1, e[7:0]});
        K_WR: check(wr_stb && wr_cmd == e[15:8] && 8'(wr_len) == e[7:0], tag,
                    {wr_stb, wr_cmd, 8'(wr_len)}, {1'b1, e});
        K_RD: check(rdb == e[7:0], tag, rdb, e[7:0]);
        K_NS: check({quick_stb, send_stb, wr_stb} == 3'b0, tag, {quick_stb, send_stb, wr_stb}, 0);
        default: ;
      endcase
    end

    // R3 payload layout
    step(E_SW, 0); step(E_WB, 8'h10); step(E_WB, 8'h11); step(E_WB, 8'h12); step(E_SP, 0);
    check(wr_payload[15:0] == 16'h1211, "R3", wr_payload[15:0], 16'h1211);

    // R11 overflow: seven bytes into a six-byte buffer
    step(E_SW, 0);
    for (int b = 0; b < 6; b++) step(E_WB, 8'hA0 + 8'(b));
    check(buf_ovf == 1'b0, "R11", buf_ovf, 0);
    step(E_WB, 8'hA6);
    check(buf_ovf == 1'b1, "R11", buf_ovf, 1);
    step(E_SP, 0);
    check(wr_stb && wr_cmd == 8'hA0 && wr_len == LENW'(5), "R11",
          {wr_stb, wr_cmd, 8'(wr_len)}, {1'b1, 8'hA0, 8'd5});
    check(wr_payload[39:32] == 8'hA5, "R11", wr_payload[39:32], 8'hA5);
    step(E_SW, 0);
    check(buf_ovf == 1'b0, "R11", buf_ovf, 0);
    step(E_SP, 0);

    // R7 index wraps after 2^IDXW reads
    step(E_SW, 0); step(E_WB, 8'h40); step(E_SR, 0);
    for (int n = 0; n < 9; n++) begin
      step(E_RB, 0);
      check(rdreq && rdb == 8'h40 + 8'(n % 8), "R7", rdb, 8'h40 + 8'(n % 8));
    end
    step(E_NK, 0);
    step(E_SP, 0);
    check(proto_err == 1'b0, "R10", proto_err, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule